// File: doc/BRIEF.md
# Status Register and Branch Condition Unit

This block holds an eight-bit processor status word and answers branch and skip questions about it. An ALU pushes flag results through a per-bit write mask. A decoder can force one flag to 1 or 0 by index, copy one bit of a general register into the transfer flag, read a register back with one bit replaced by the transfer flag, and signal an interrupt return, which re-enables interrupts.

A condition query picks a mode and a flag index. One cycle later the block returns whether the branch is taken. The signed modes use the exclusive-OR of the negative and overflow flags, and the unsigned modes use the carry. All outputs are registered and are cleared by a synchronous active-high reset.

Top module: `psw_cond_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next values of `flags_q`, `taken_q` and `load_q` are all zero.
- R2: The flag layout is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. When `alu_we` is high, each bit whose `alu_mask` bit is 1 takes the matching `alu_flags` bit at the edge. Unmasked bits keep their value.
- R3: When an ALU update masks in N or V but does not mask in S, S becomes the exclusive-OR of the updated N and V. When S is masked in, S takes `alu_flags[4]`.
- R4: When `sc_valid` is high, flag `sc_idx` becomes `sc_set` (1 = set, 0 = clear) at the edge. Every other bit is unchanged.
- R5: A set/clear wins over an ALU update, a bit-store or an interrupt return that writes the same bit in the same cycle.
- R6: When `xfer_store` is high, T (bit 6) becomes `xfer_operand[xfer_idx]` at the edge, and no other flag changes.
- R7: At every edge, `load_q` becomes `xfer_operand` with bit `xfer_idx` replaced by the T value held before that edge. Producing this result changes no flag.
- R8: When `irq_ret` is high, I (bit 7) becomes 1 at the edge.
- R9: The query is registered, so `taken_q` after an edge reflects the flags held before that edge. Mode 0 is taken when flag `cq_sel` is 1, and mode 1 is taken when flag `cq_sel` is 0.
- R10: Mode 2 (signed greater-or-equal) is taken when N XOR V is 0. Mode 3 (signed less-than) is taken when N XOR V is 1.
- R11: Mode 4 (same-or-higher) is taken when C is 0, and mode 5 (lower) is taken when C is 1. Modes 6 and 7 are never taken.
- R12: In a cycle with no ALU update, set/clear, bit-store or interrupt return, `flags_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| alu_we | input | 1 | ALU flag update strobe |
| alu_mask | input | 8 | Per-flag write enable for the ALU update |
| alu_flags | input | 8 | Flag values from the ALU |
| sc_valid | input | 1 | Single-flag set/clear strobe |
| sc_set | input | 1 | 1 sets the flag, 0 clears it |
| sc_idx | input | 3 | Index of the flag to set or clear |
| xfer_store | input | 1 | Copy the selected operand bit into T |
| xfer_idx | input | 3 | Operand bit index for store and load |
| xfer_operand | input | 8 | General register operand |
| irq_ret | input | 1 | Interrupt return, sets I |
| cq_mode | input | 3 | Condition mode 0..7 |
| cq_sel | input | 3 | Flag index for modes 0 and 1 |
| flags_q | output | 8 | Current status word |
| taken_q | output | 1 | Registered condition result |
| load_q | output | 8 | Registered operand with the selected bit replaced by T |

## Verification
The bench targets same-cycle collisions. If the set/clear loses to the ALU, the bit-store or the interrupt return on a shared bit, that bit shows the losing writer's value. The sign-derivation vectors separate the case where S is rebuilt from N and V from the case where S is written explicitly, so a design that always derives S, or never does, ends with the wrong S. Every mode is swept against flag patterns where N and V agree or differ and where C is set or clear. A swapped polarity, or a signed test that reads only N, returns the wrong taken bit. The bit-load is checked with both values of T on an operand whose selected bit holds the opposite value, so an ignored T or a wrong bit index shows up at `load_q`.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int FLAG_W = 8;
  localparam int FIDX_W = $clog2(FLAG_W);

  // Fixed flag positions; the condition logic decodes these.
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;
  localparam int F_T = 6;
  localparam int F_I = 7;

  typedef enum logic [2:0] {
    CQ_FLAG_SET = 3'd0,
    CQ_FLAG_CLR = 3'd1,
    CQ_SGE      = 3'd2,
    CQ_SLT      = 3'd3,
    CQ_USH      = 3'd4,
    CQ_ULO      = 3'd5,
    CQ_NONE6    = 3'd6,
    CQ_NONE7    = 3'd7
  } cq_mode_e;
endpackage

// File: rtl/psw_flag_merge.sv
module psw_flag_merge
  import psw_pkg::*;
(
  input  logic [FLAG_W-1:0] cur,
  input  logic              alu_we,
  input  logic [FLAG_W-1:0] alu_mask,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic              sc_valid,
  input  logic              sc_set,
  input  logic [FIDX_W-1:0] sc_idx,
  input  logic              st_valid,
  input  logic              st_bit,
  input  logic              irq_ret,
  output logic [FLAG_W-1:0] nxt
);
  logic [FLAG_W-1:0] alu_stage;
  logic [FLAG_W-1:0] mid_stage;
  logic              derive_s;
  logic              s_value;

  // Stage 1: masked ALU write.
  always_comb begin
    for (int k = 0; k < FLAG_W; k++)
      alu_stage[k] = (alu_we && alu_mask[k]) ? alu_flags[k] : cur[k];
  end

  // Sign is rebuilt from the post-update N and V unless written explicitly.
  assign derive_s = alu_we && (alu_mask[F_N] || alu_mask[F_V]) && !alu_mask[F_S];
  assign s_value  = derive_s ? (alu_stage[F_N] ^ alu_stage[F_V]) : alu_stage[F_S];

  // Stage 2: dedicated writers (bit-store on T, interrupt return on I).
  // Stage 3: indexed set/clear, highest priority.
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (i == F_S) begin : g_sign
      assign mid_stage[i] = s_value;
    end else if (i == F_T) begin : g_xfer
      assign mid_stage[i] = st_valid ? st_bit : alu_stage[i];
    end else if (i == F_I) begin : g_ien
      assign mid_stage[i] = irq_ret ? 1'b1 : alu_stage[i];
    end else begin : g_plain
      assign mid_stage[i] = alu_stage[i];
    end
    assign nxt[i] = (sc_valid && (sc_idx == FIDX_W'(i))) ? sc_set : mid_stage[i];
  end
endmodule

// File: rtl/psw_bit_xfer.sv
module psw_bit_xfer #(
  parameter int DATA_W = 8,
  localparam int XIDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand,
  input  logic [XIDX_W-1:0] idx,
  input  logic              t_in,
  output logic              store_bit,
  output logic [DATA_W-1:0] load_value
);
  assign store_bit = operand[idx];

  for (genvar i = 0; i < DATA_W; i++) begin : g_ld
    assign load_value[i] = (idx == XIDX_W'(i)) ? t_in : operand[i];
  end
endmodule

// File: rtl/psw_cond_eval.sv
module psw_cond_eval
  import psw_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [2:0]        mode,
  input  logic [FIDX_W-1:0] sel,
  output logic              taken
);
  logic       picked;
  logic       lt_signed;
  cq_mode_e   m;

  assign m         = cq_mode_e'(mode);
  assign picked    = flags[sel];
  assign lt_signed = flags[F_N] ^ flags[F_V];

  always_comb begin
    unique case (m)
      CQ_FLAG_SET: taken = picked;
      CQ_FLAG_CLR: taken = !picked;
      CQ_SGE:      taken = !lt_signed;
      CQ_SLT:      taken = lt_signed;
      CQ_USH:      taken = !flags[F_C];
      CQ_ULO:      taken = flags[F_C];
      default:     taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/psw_cond_unit.sv
module psw_cond_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int XIDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_we,
  input  logic [FLAG_W-1:0] alu_mask,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic              sc_valid,
  input  logic              sc_set,
  input  logic [FIDX_W-1:0] sc_idx,
  input  logic              xfer_store,
  input  logic [XIDX_W-1:0] xfer_idx,
  input  logic [DATA_W-1:0] xfer_operand,
  input  logic              irq_ret,
  input  logic [2:0]        cq_mode,
  input  logic [FIDX_W-1:0] cq_sel,
  output logic [FLAG_W-1:0] flags_q,
  output logic              taken_q,
  output logic [DATA_W-1:0] load_q
);
  logic [FLAG_W-1:0] flags_nxt;
  logic              st_bit;
  logic [DATA_W-1:0] load_nxt;
  logic              taken_nxt;

  psw_bit_xfer #(.DATA_W(DATA_W)) u_xfer (
    .operand    (xfer_operand),
    .idx        (xfer_idx),
    .t_in       (flags_q[F_T]),
    .store_bit  (st_bit),
    .load_value (load_nxt)
  );

  psw_flag_merge u_merge (
    .cur       (flags_q),
    .alu_we    (alu_we),
    .alu_mask  (alu_mask),
    .alu_flags (alu_flags),
    .sc_valid  (sc_valid),
    .sc_set    (sc_set),
    .sc_idx    (sc_idx),
    .st_valid  (xfer_store),
    .st_bit    (st_bit),
    .irq_ret   (irq_ret),
    .nxt       (flags_nxt)
  );

  psw_cond_eval u_cond (
    .flags (flags_q),
    .mode  (cq_mode),
    .sel   (cq_sel),
    .taken (taken_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      taken_q <= 1'b0;
      load_q  <= '0;
    end else begin
      flags_q <= flags_nxt;
      taken_q <= taken_nxt;
      load_q  <= load_nxt;
    end
  end

  // R1: reset clears every output.
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (flags_q == '0 && !taken_q && load_q == '0));

  // R12: no writer active means the word holds.
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!alu_we && !sc_valid && !xfer_store && !irq_ret) |=> $stable(flags_q));

  // R5: the indexed set/clear always lands.
  p_sc_wins_r5: assert property (@(posedge clk) disable iff (rst)
    sc_valid |=> (flags_q[$past(sc_idx)] == $past(sc_set)));

  // R8: interrupt return enables I unless a clear on bit 7 overrides.
  p_irq_ret_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_ret && !(sc_valid && sc_idx == FIDX_W'(F_I))) |=> flags_q[F_I]);

  // R6: bit-store copies the operand bit into T.
  p_store_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_store && !(sc_valid && sc_idx == FIDX_W'(F_T)))
      |=> (flags_q[F_T] == $past(xfer_operand[xfer_idx])));

  // R3: derived sign after an N/V update with S unmasked.
  p_sign_derive_r3: assert property (@(posedge clk) disable iff (rst)
    (alu_we && (alu_mask[F_N] || alu_mask[F_V]) && !alu_mask[F_S] && !sc_valid)
      |=> (flags_q[F_S] == (flags_q[F_N] ^ flags_q[F_V])));

  // R10: signed less-than follows N xor V of the previous word.
  p_slt_r10: assert property (@(posedge clk) disable iff (rst)
    (cq_mode == 3'd3) |=> (taken_q == ($past(flags_q[F_N]) ^ $past(flags_q[F_V]))));

  // R11: reserved modes never report taken.
  p_reserved_r11: assert property (@(posedge clk) disable iff (rst)
    (cq_mode == 3'd6 || cq_mode == 3'd7) |=> !taken_q);
endmodule

// File: tb/psw_cond_unit_tb_top.sv
module psw_cond_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alu_we = 1'b0;
  logic [7:0] alu_mask = '0;
  logic [7:0] alu_flags = '0;
  logic       sc_valid = 1'b0;
  logic       sc_set = 1'b0;
  logic [2:0] sc_idx = '0;
  logic       xfer_store = 1'b0;
  logic [2:0] xfer_idx = '0;
  logic [7:0] xfer_operand = '0;
  logic       irq_ret = 1'b0;
  logic [2:0] cq_mode = '0;
  logic [2:0] cq_sel = '0;
  logic [7:0] flags_q;
  logic       taken_q;
  logic [7:0] load_q;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_cond_unit dut_i (
    .clk(clk), .rst(rst), .alu_we(alu_we), .alu_mask(alu_mask),
    .alu_flags(alu_flags), .sc_valid(sc_valid), .sc_set(sc_set),
    .sc_idx(sc_idx), .xfer_store(xfer_store), .xfer_idx(xfer_idx),
    .xfer_operand(xfer_operand), .irq_ret(irq_ret), .cq_mode(cq_mode),
    .cq_sel(cq_sel), .flags_q(flags_q), .taken_q(taken_q), .load_q(load_q)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] mask;
    logic [7:0] af;
    logic       scv;
    logic       scs;
    logic [2:0] sci;
    logic       st;
    logic [2:0] sti;
    logic [7:0] op;
    logic       irq;
    logic [7:0] exp;
  } vec_t;

  // Applied in order from the reset word 0x00.
  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'hFF, 8'h2D, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h2D}, // R2 full write
    '{1'b1, 8'h0C, 8'h04, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h35}, // R3 S derived 1
    '{1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00, 1'b0, 8'hB5}, // R4 set I
    '{1'b1, 8'h01, 8'h00, 1'b1, 1'b1, 3'd0, 1'b0, 3'd0, 8'h00, 1'b0, 8'hB5}, // R5 set C beats ALU
    '{1'b1, 8'h20, 8'h20, 1'b1, 1'b0, 3'd5, 1'b0, 3'd0, 8'h00, 1'b0, 8'h95}, // R5 clear H beats ALU
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 8'h08, 1'b0, 8'hD5}, // R6 store 1
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b1, 3'd0, 8'hFE, 1'b0, 8'h95}, // R6 store 0
    '{1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 3'd7, 1'b0, 3'd0, 8'h00, 1'b0, 8'h15}, // R4 clear I
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 1'b1, 8'h95}, // R8 irq return
    '{1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 3'd7, 1'b0, 3'd0, 8'h00, 1'b1, 8'h15}, // R5 clear beats irq
    '{1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'hFF, 1'b0, 8'h15}, // R12 idle
    '{1'b1, 8'h08, 8'h08, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h0D}, // R3 S derived 0
    '{1'b1, 8'h18, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h05}, // R3 S explicit
    '{1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 3'd6, 1'b1, 3'd0, 8'h01, 1'b0, 8'h05}  // R5 clear beats store
  };

  function automatic logic cond_exp(input logic [7:0] f, input int mode, input int sel);
    case (mode)
      0: return f[sel];
      1: return !f[sel];
      2: return !(f[2] ^ f[3]);
      3: return f[2] ^ f[3];
      4: return !f[0];
      5: return f[0];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic idle_inputs();
    alu_we = 0; alu_mask = 0; alu_flags = 0; sc_valid = 0; sc_set = 0;
    sc_idx = 0; xfer_store = 0; xfer_idx = 0; irq_ret = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_word(input logic [7:0] w);
    @(negedge clk);
    idle_inputs();
    alu_we = 1; alu_mask = 8'hFF; alu_flags = w;
    tick();
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pats [6];
    pats = '{8'h00, 8'hFF, 8'h04, 8'h0C, 8'h08, 8'h01};

    repeat (3) @(posedge clk);
    #1;
    chk("R1 flags after reset", flags_q, 8'h00);
    chk("R1 taken after reset", taken_q, 1'b0);
    chk("R1 load after reset", load_q, 8'h00);
    @(negedge clk);
    rst = 0;

    // Vector walk.
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      alu_we = VECS[v].we; alu_mask = VECS[v].mask; alu_flags = VECS[v].af;
      sc_valid = VECS[v].scv; sc_set = VECS[v].scs; sc_idx = VECS[v].sci;
      xfer_store = VECS[v].st; xfer_idx = VECS[v].sti; xfer_operand = VECS[v].op;
      irq_ret = VECS[v].irq;
      tick();
      chk($sformatf("R2/R3/R4/R5/R6/R8/R12 vector %0d", v), flags_q, VECS[v].exp);
    end
    @(negedge clk);
    idle_inputs();

    // Condition sweep (R9 modes 0/1, R10 modes 2/3, R11 modes 4..7).
    foreach (pats[p]) begin
      load_word(pats[p]);
      for (int m = 0; m < 8; m++) begin
        for (int s = 0; s < 8; s++) begin
          @(negedge clk);
          cq_mode = 3'(m); cq_sel = 3'(s);
          tick();
          chk($sformatf("%s mode %0d sel %0d word %0h",
                        (m < 2) ? "R9" : (m < 4) ? "R10" : "R11", m, s, pats[p]),
              taken_q, cond_exp(pats[p], m, s));
        end
      end
      chk("R12 query leaves flags", flags_q, pats[p]);
    end

    // Bit-load with T = 1, then T = 0.
    load_word(8'h40);
    @(negedge clk);
    xfer_operand = 8'h00; xfer_idx = 3'd4;
    tick();
    chk("R7 load T=1 into bit 4", load_q, 8'h10);
    chk("R7 load leaves flags", flags_q, 8'h40);
    load_word(8'h00);
    @(negedge clk);
    xfer_operand = 8'hFF; xfer_idx = 3'd2;
    tick();
    chk("R7 load T=0 into bit 2", load_q, 8'hFB);
    chk("R7 load leaves flags T=0", flags_q, 8'h00);

    // Mid-run reset.
    load_word(8'hA5);
    @(negedge clk);
    cq_mode = 3'd0; cq_sel = 3'd0;
    rst = 1;
    tick();
    chk("R1 mid-run reset flags", flags_q, 8'h00);
    chk("R1 mid-run reset taken", taken_q, 1'b0);
    chk("R1 mid-run reset load", load_q, 8'h00);
    @(negedge clk);
    rst = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule